// File: doc/BRIEF.md
# Registered Two-Port Bus Transceiver

This block links two 8-bit buses, called A and B. Each bus has its own storage register, and each register is loaded from its own bus by its own clock. Each transfer direction then drives its destination bus from one of two sources: the live value on the opposite bus, or the value held in that side's register. Each direction has a separate source select and a separate output enable. A register loads on its clock edge whatever the selects and enables are set to.

Each bus appears at the boundary as three signals: a sampled input vector, a driven output vector and an output-enable. The enclosing design, or a pad ring, resolves these into a physical bus, so no tri-state net is needed inside the block. Suppose both directions pass live data and both are enabled. Each bus then drives back the value it already carries, so the pair of buses keeps its last state after every outside driver lets go. The select multiplexer is built from hazard-free logic, so switching between live and stored data gives a single clean change at the output.

Top module: `twin_store_xcvr`

## Requirements
- R1: The data path is `WIDTH` bits wide (default 8), and every bit position uses the same channel logic.
- R2: On each rising edge of `a_clk` while `rst` is low, the A-side store loads `a_in`. The A-side store is the stored source for the A-to-B direction.
- R3: On each rising edge of `b_clk` while `rst` is low, the B-side store loads `b_in`. An `a_clk` edge leaves the B-side store unchanged, and a `b_clk` edge leaves the A-side store unchanged.
- R4: A store loads on its clock edge for every combination of `ab_src`, `ba_src`, `ab_en` and `ba_en_n`.
- R5: When `ab_src` is 0, `b_out` equals `a_in`. When `ba_src` is 0, `a_out` equals `b_in`.
- R6: When `ab_src` is 1, `b_out` equals the A-side store. When `ba_src` is 1, `a_out` equals the B-side store.
- R7: `b_oe` equals `ab_en`, which is active high. `a_oe` equals the inverse of `ba_en_n`, which is active low.
- R8: With both selects at 0, `ab_en` at 1 and `ba_en_n` at 0, the two buses settle to the value of whichever bus was last driven from outside. They keep that value after the outside driver is released.
- R9: When a select changes while the data stays fixed, the output moves straight from the old source value to the new one. Where a bit has the same value in both sources, that bit does not change.
- R10: `rst` is synchronous and active high. It clears the A-side store on an `a_clk` edge and the B-side store on a `b_clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Load clock for the A-side store |
| b_clk | input | 1 | Load clock for the B-side store |
| rst | input | 1 | Synchronous active-high clear of both stores |
| ab_en | input | 1 | A-to-B drive enable, active high |
| ba_en_n | input | 1 | B-to-A drive enable, active low |
| ab_src | input | 1 | A-to-B source select: 0 live, 1 stored |
| ba_src | input | 1 | B-to-A source select: 0 live, 1 stored |
| a_in | input | WIDTH | Value sampled from the A bus |
| b_in | input | WIDTH | Value sampled from the B bus |
| b_out | output | WIDTH | Value the block drives onto the B bus |
| b_oe | output | 1 | Drive enable for the B bus |
| a_out | output | WIDTH | Value the block drives onto the A bus |
| a_oe | output | 1 | Drive enable for the A bus |

## Verification
The assertions check four things on every cycle and every input change: the source relation of each output (live or stored), the polarity of both enables, the load on each clock edge and the clear under reset. The bench sweeps all sixteen control combinations across several data patterns, and it loads the stores under each combination. Bus-hold behaviour involves the outside world, so only the bench's resolution model can show it: that model feeds each resolved bus back into the block and then releases the outside driver. The bench also checks a source switch with the data held fixed, and the independence of the two store clocks.

// File: rtl/twin_store_xcvr_pkg.sv
package twin_store_xcvr_pkg;

    localparam int unsigned XCVR_W = 8;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    typedef struct packed {
        src_sel_e src;
        logic     drive;
    } dir_ctl_t;

    // Hazard-free 2:1 select for one bit; the consensus term keeps the
    // output steady when both sources agree while the select moves.
    function automatic logic clean_pick(input logic sel, input logic live, input logic stored);
        return (live & ~sel) | (stored & sel) | (live & stored);
    endfunction

endpackage

// File: rtl/twin_store_reg.sv
module twin_store_reg #(
    parameter int unsigned WIDTH = twin_store_xcvr_pkg::XCVR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/twin_src_mux.sv
module twin_src_mux
    import twin_store_xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = XCVR_W
) (
    input  dir_ctl_t         ctl,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] dout,
    output logic             oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign dout[i] = clean_pick(ctl.src == SRC_STORED, live[i], stored[i]);
    end
    assign oe = ctl.drive;
endmodule

// File: rtl/twin_store_xcvr.sv
module twin_store_xcvr
    import twin_store_xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = XCVR_W
) (
    input  logic             a_clk,
    input  logic             b_clk,
    input  logic             rst,
    input  logic             ab_en,
    input  logic             ba_en_n,
    input  logic             ab_src,
    input  logic             ba_src,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe
);
    logic [WIDTH-1:0] a_store;
    logic [WIDTH-1:0] b_store;
    dir_ctl_t         ab_ctl;
    dir_ctl_t         ba_ctl;

    assign ab_ctl.src   = src_sel_e'(ab_src);
    assign ab_ctl.drive = ab_en;
    assign ba_ctl.src   = src_sel_e'(ba_src);
    assign ba_ctl.drive = ~ba_en_n;

    twin_store_reg #(.WIDTH(WIDTH)) u_a_reg (
        .clk(a_clk), .rst(rst), .d(a_in), .q(a_store)
    );

    twin_store_reg #(.WIDTH(WIDTH)) u_b_reg (
        .clk(b_clk), .rst(rst), .d(b_in), .q(b_store)
    );

    twin_src_mux #(.WIDTH(WIDTH)) u_ab_mux (
        .ctl(ab_ctl), .live(a_in), .stored(a_store), .dout(b_out), .oe(b_oe)
    );

    twin_src_mux #(.WIDTH(WIDTH)) u_ba_mux (
        .ctl(ba_ctl), .live(b_in), .stored(b_store), .dout(a_out), .oe(a_oe)
    );
endmodule

// File: rtl/twin_store_xcvr_chk.sv
module twin_store_xcvr_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             a_clk,
    input logic             b_clk,
    input logic             rst,
    input logic             ab_en,
    input logic             ba_en_n,
    input logic             ab_src,
    input logic             ba_src,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] a_store,
    input logic [WIDTH-1:0] b_store
);
    // R2, R4: A store follows a_in at every a_clk edge
    a_r2_a_load: assert property (@(posedge a_clk) disable iff (rst)
        1'b1 |=> (a_store == $past(a_in)));

    // R3: B store follows b_in at every b_clk edge
    a_r3_b_load: assert property (@(posedge b_clk) disable iff (rst)
        1'b1 |=> (b_store == $past(b_in)));

    // R10: clear on each side's own edge
    a_r10_a_clear: assert property (@(posedge a_clk) rst |=> (a_store == '0));
    a_r10_b_clear: assert property (@(posedge b_clk) rst |=> (b_store == '0));

    always_comb begin
        if (!rst) begin
            // R5: live path
            if (!ab_src) a_r5_live_ab: assert (b_out == a_in);
            if (!ba_src) a_r5_live_ba: assert (a_out == b_in);
            // R6: stored path
            if (ab_src)  a_r6_stored_ab: assert (b_out == a_store);
            if (ba_src)  a_r6_stored_ba: assert (a_out == b_store);
            // R7: enable polarity
            a_r7_enables: assert ((b_oe == ab_en) && (a_oe == !ba_en_n));
        end
    end
endmodule

bind twin_store_xcvr twin_store_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
    .a_clk(a_clk), .b_clk(b_clk), .rst(rst),
    .ab_en(ab_en), .ba_en_n(ba_en_n), .ab_src(ab_src), .ba_src(ba_src),
    .a_in(a_in), .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .a_out(a_out), .a_oe(a_oe), .a_store(a_store), .b_store(b_store)
);

// File: tb/twin_store_xcvr_bench.sv
module twin_store_xcvr_bench;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;

    logic         tick = 0;
    logic         a_clk = 0, b_clk = 0, rst = 1;
    logic         ab_en = 0, ba_en_n = 1, ab_src = 0, ba_src = 0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] b_out, a_out;
    logic         b_oe, a_oe;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    twin_store_xcvr #(.WIDTH(W)) u_twin_store_xcvr (
        .a_clk(a_clk), .b_clk(b_clk), .rst(rst),
        .ab_en(ab_en), .ba_en_n(ba_en_n), .ab_src(ab_src), .ba_src(ba_src),
        .a_in(a_in), .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .a_out(a_out), .a_oe(a_oe)
    );

    always #(CLK_PERIOD/2) tick = ~tick;

    always @(posedge tick) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic pulse_a();
        #(CLK_PERIOD/2) a_clk = 1;
        #(CLK_PERIOD/2) a_clk = 0;
    endtask

    task automatic pulse_b();
        #(CLK_PERIOD/2) b_clk = 1;
        #(CLK_PERIOD/2) b_clk = 0;
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bus resolution model for hold mode
    logic [W-1:0] a_bus = '0, b_bus = '0;
    logic         ext_a_on = 0, ext_b_on = 0;
    logic [W-1:0] ext_a = '0, ext_b = '0;

    task automatic resolve();
        for (int k = 0; k < 4; k++) begin
            a_bus = ext_a_on ? ext_a : (a_oe ? a_out : a_bus);
            b_bus = ext_b_on ? ext_b : (b_oe ? b_out : b_bus);
            a_in = a_bus;
            b_in = b_bus;
            #1;
        end
    endtask

    initial begin
        logic [W-1:0] pats [3];
        pats[0] = 8'hA5; pats[1] = 8'h0F; pats[2] = 8'hFF;

        // R10: reset clears both stores
        rst = 1; a_in = 8'h77; b_in = 8'h99;
        pulse_a(); pulse_b();
        rst = 0; ab_src = 1; ba_src = 1; #1;
        check("R10 a store clear", b_out, '0);
        check("R10 b store clear", a_out, '0);

        // R1 R2 R4 R5 R6 R7: sweep all control combos and patterns
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 16; c++) begin
                logic [W-1:0] sa, sb, la, lb;
                sa = pats[p] ^ W'(c);
                sb = ~pats[p] + W'(c * 3);
                {ab_src, ba_src, ab_en, ba_en_n} = 4'(c);
                a_in = sa; b_in = sb;
                pulse_a(); pulse_b();          // R4: load under this combo
                la = sa ^ 8'h5A; lb = ~sb;
                a_in = la; b_in = lb; #1;
                check("R5R6 b_out", b_out, ab_src ? sa : la);
                check("R5R6 a_out", a_out, ba_src ? sb : lb);
                check("R7 b_oe", {7'd0, b_oe}, {7'd0, ab_en});
                check("R7 a_oe", {7'd0, a_oe}, {7'd0, ~ba_en_n});
            end
        end

        // R2 R3: clocks are independent
        ab_src = 1; ba_src = 1;
        a_in = 8'h12; b_in = 8'h34; pulse_a(); pulse_b();
        a_in = 8'hC3; pulse_a();
        b_in = 8'hEE; #1;
        check("R3 b store untouched by a_clk", a_out, 8'h34);
        check("R2 a store loaded", b_out, 8'hC3);
        b_in = 8'h5D; pulse_b();
        a_in = 8'h00; #1;
        check("R3 b store loaded", a_out, 8'h5D);
        check("R2 a store untouched by b_clk", b_out, 8'hC3);

        // R9: select switch with fixed data, both directions
        a_in = 8'h3C; pulse_a();       // a store = 3C
        a_in = 8'h5A; ab_src = 0; #1;
        check("R9 live before switch", b_out, 8'h5A);
        ab_src = 1; #1;
        check("R9 stored after switch", b_out, 8'h3C);
        ab_src = 0; #1;
        check("R9 back to live", b_out, 8'h5A);

        // R8: bus hold with both directions live and enabled
        ab_src = 0; ba_src = 0; ab_en = 1; ba_en_n = 0;
        ext_a_on = 1; ext_a = 8'h6B; ext_b_on = 0;
        resolve();
        check("R8 b bus follows a driver", b_bus, 8'h6B);
        ext_a_on = 0; resolve();
        check("R8 a bus held", a_bus, 8'h6B);
        check("R8 b bus held", b_bus, 8'h6B);
        ext_b_on = 1; ext_b = 8'h91; resolve();
        ext_b_on = 0; resolve();
        check("R8 a bus takes b value", a_bus, 8'h91);
        check("R8 b bus held after release", b_bus, 8'h91);

        // R10: reset mid-run clears again
        rst = 1; pulse_a(); pulse_b(); rst = 0;
        ab_src = 1; ba_src = 1; #1;
        check("R10 a store cleared again", b_out, '0);
        check("R10 b store cleared again", a_out, '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule